// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address presented to a synchronous burst memory port. A single load/advance control chooses, on each enabled clock edge, between taking a fresh address from outside and stepping the current burst to its next internal address. One supplied address therefore covers four consecutive accesses. Only the two lowest address bits move during a burst. The upper bits stay at the loaded value.

The order of the low bits is fixed when the burst starts. In linear order the low bits count upward with wrap-around. In interleaved order they are the starting value XORed with a running beat count. A select input set low during a load turns the cycle into a deselect. Later advance cycles still step the address, but they flag no access. A clock enable set low freezes every piece of state. The asynchronous reset is released synchronously inside the block.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, acc_addr is 0 and acc_valid is 0.
- R2: On an enabled edge with load_adv=1 and sel=1, acc_addr equals the sampled ext_addr and acc_valid is 1 from the following cycle.
- R3: On an enabled edge with load_adv=0 (advance), the upper address bits (above bit 1) of acc_addr do not change.
- R4: In linear order, the low two bits on beat k (k=0..3 after the load) equal (start + k) mod 4. For example, start 1 gives 1,2,3,0.
- R5: In interleaved order, the low two bits on beat k equal start XOR k. For example, start 1 gives 1,0,3,2.
- R6: After the fourth beat, further advance cycles wrap the low bits back to the starting value, and the sequence repeats.
- R7: order_ilv (0 = linear, 1 = interleaved) is sampled only on a load with sel=1. Changing it during a burst has no effect on the order.
- R8: On an enabled edge with load_adv=1 and sel=0 (deselect), acc_valid becomes 0 and acc_addr is held.
- R9: An advance cycle after a deselect steps acc_addr through the burst order, and acc_valid stays 0.
- R10: When clk_en=0, acc_addr and acc_valid hold their values, and load_adv, sel, ext_addr and order_ilv are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; 0 stalls the sequencer |
| load_adv | input | 1 | 1 = load new address or deselect, 0 = advance burst |
| sel | input | 1 | Select, sampled with load_adv=1; 0 means deselect |
| ext_addr | input | ADDR_W | Externally supplied start address |
| order_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| acc_addr | output | ADDR_W | Current access address |
| acc_valid | output | 1 | 1 when the current cycle performs an access |

## Verification
A wrong beat count or a wrong latched order shows up on the low two bits of acc_addr on the first advance after the fault. A wrong starting value shows up already on the cycle after the load. A corrupted upper field appears at once and remains until the next load. A lost deselect flag shows as acc_valid rising during a continued burst on the next edge. A stall that leaks shows as an address change one cycle after clk_en falls.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clear,
  input  logic          step,
  output logic [BW-1:0] beat
);
  logic [BW-1:0] beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (clear)     beat_d = '0;
    else if (step) beat_d = beat_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  beat_q <= '0;
    else if (en) beat_q <= beat_d;
  end

  assign beat = beat_q;
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_seq_pkg::*;
#(
  parameter int BW = 2
) (
  input  logic          [BW-1:0] start,
  input  logic          [BW-1:0] beat,
  input  burst_order_e           order,
  output logic          [BW-1:0] low
);
  logic [BW-1:0] lin_low, ilv_low;

  assign lin_low = start + beat;

  for (genvar i = 0; i < BW; i++) begin : g_xor
    assign ilv_low[i] = start[i] ^ beat[i];
  end

  assign low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              load_adv,
  input  logic              sel,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_valid
);
  localparam int BW = BURST_BITS;
  localparam int UW = ADDR_W - BW;

  logic          srst_n;
  logic [UW-1:0] upper_q, upper_d;
  logic [BW-1:0] start_q, start_d;
  burst_order_e  mode_q, mode_d;
  logic          valid_q, valid_d;
  logic [BW-1:0] beat;
  logic [BW-1:0] low;
  logic          do_load;

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign do_load = load_adv & sel;

  always_comb begin
    upper_d = upper_q;
    start_d = start_q;
    mode_d  = mode_q;
    valid_d = valid_q;
    if (load_adv) begin
      if (sel) begin
        upper_d = ext_addr[ADDR_W-1:BW];
        start_d = ext_addr[BW-1:0];
        mode_d  = burst_order_e'(order_ilv);
        valid_d = 1'b1;
      end else begin
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      upper_q <= '0;
      start_q <= '0;
      mode_q  <= ORD_LINEAR;
      valid_q <= 1'b0;
    end else if (clk_en) begin
      upper_q <= upper_d;
      start_q <= start_d;
      mode_q  <= mode_d;
      valid_q <= valid_d;
    end
  end

  burst_beat_ctr #(.BW(BW)) u_beat (
    .clk   (clk),
    .rst_n (srst_n),
    .en    (clk_en),
    .clear (do_load),
    .step  (~load_adv),
    .beat  (beat)
  );

  burst_low_map #(.BW(BW)) u_map (
    .start (start_q),
    .beat  (beat),
    .order (mode_q),
    .low   (low)
  );

  assign acc_addr  = {upper_q, low};
  assign acc_valid = valid_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BW = 2
) (
  input logic              clk,
  input logic              srst_n,
  input logic              clk_en,
  input logic              load_adv,
  input logic              sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              mode_bit,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_valid
);
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!srst_n)
    clk_en && load_adv && sel |=> acc_valid && acc_addr == $past(ext_addr));

  // R3
  upper_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    clk_en && !load_adv |=> acc_addr[ADDR_W-1:BW] == $past(acc_addr[ADDR_W-1:BW]));

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    clk_en && !load_adv && !mode_bit |=> acc_addr[BW-1:0] == BW'($past(acc_addr[BW-1:0]) + 1'b1));

  // R8
  deselect_chk: assert property (@(posedge clk) disable iff (!srst_n)
    clk_en && load_adv && !sel |=> !acc_valid && $stable(acc_addr));

  // R9
  continue_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    clk_en && !load_adv && !acc_valid |=> !acc_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !clk_en |=> $stable(acc_addr) && $stable(acc_valid));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BW(BW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .clk_en    (clk_en),
  .load_adv  (load_adv),
  .sel       (sel),
  .ext_addr  (ext_addr),
  .mode_bit  (mode_q),
  .acc_addr  (acc_addr),
  .acc_valid (acc_valid)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [AW-1:0] a;
    logic          v;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          load_adv = 1'b0;
  logic          sel = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          order_ilv = 1'b0;
  logic [AW-1:0] acc_addr;
  logic          acc_valid;

  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  exp_t sb_q[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_start = '0;
  logic [1:0]    m_beat = '0;
  logic          m_ilv = 1'b0;
  logic          m_act = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .load_adv  (load_adv),
    .sel       (sel),
    .ext_addr  (ext_addr),
    .order_ilv (order_ilv),
    .acc_addr  (acc_addr),
    .acc_valid (acc_valid)
  );

  task automatic check(input logic [AW-1:0] ga, input logic gv,
                       input logic [AW-1:0] ea, input logic ev, input string tag);
    total++;
    if (ga !== ea || gv !== ev) begin
      bad++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b", tag, ga, gv, ea, ev);
    end
  endtask

  task automatic cyc(input logic ce, input logic la, input logic s,
                     input logic [AW-1:0] a, input logic ilv, input string tag);
    exp_t e;
    logic [1:0] lo;
    @(negedge clk);
    clk_en = ce; load_adv = la; sel = s; ext_addr = a; order_ilv = ilv;
    if (ce) begin
      if (la) begin
        if (s) begin
          m_base = a; m_start = a[1:0]; m_beat = 2'd0; m_ilv = ilv; m_act = 1'b1;
        end else m_act = 1'b0;
      end else m_beat = m_beat + 2'd1;
    end
    lo = m_ilv ? (m_start ^ m_beat) : (m_start + m_beat);
    e.a = {m_base[AW-1:2], lo};
    e.v = m_act;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(acc_addr, acc_valid, e.a, e.v, e.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(acc_addr, acc_valid, '0, 1'b0, "R1");

    // R2 R4 R6: linear from low 1, wrap past four beats
    cyc(1, 1, 1, 20'h12345, 0, "R2");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, '0, 0, "R4_R6 linear");

    // R2 R5 R6: interleaved from low 1, then from 2 and 3
    cyc(1, 1, 1, 20'hABCD1, 1, "R2");
    for (int i = 0; i < 5; i++) cyc(1, 0, 1, '0, 1, "R5_R6 interleave");
    cyc(1, 1, 1, 20'h0F0F2, 1, "R2");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, '0, 0, "R5 start2");
    cyc(1, 1, 1, 20'h55553, 1, "R2");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, '0, 0, "R5 start3");

    // R3: linear from 3 wraps low bits without carrying upward
    cyc(1, 1, 1, 20'hFFFF3, 0, "R2");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, '0, 0, "R3 upper");

    // R7: toggling order during a burst has no effect
    cyc(1, 1, 1, 20'h33332, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, '0, (i % 2 == 0), "R7 order held");

    // R10: stall with load inputs present is ignored
    cyc(1, 1, 1, 20'h44440, 1, "R2");
    cyc(1, 0, 0, '0, 0, "R5");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 20'h99999, 0, "R10 stall");
    cyc(1, 0, 0, '0, 0, "R10 resume");

    // R8 R9: deselect, then continue steps address without access
    cyc(1, 1, 0, 20'h77777, 1, "R8 deselect");
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, '0, 0, "R9 continue");
    cyc(0, 0, 0, '0, 0, "R10 stall idle");
    cyc(1, 1, 1, 20'h2468A, 0, "R2 reload");
    cyc(1, 0, 0, '0, 0, "R4");

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule